// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block lets a small 8-bit processor core reach an external SRAM over a multiplexed bus. The low address byte and the data byte share one set of pins. An address-latch strobe tells the external latch when the low address is valid. The high address byte has pins of its own, and separate active-low read and write strobes frame the data transfer. The core pulses a request with address, write data and direction. The block raises `stall` for the whole external cycle and returns read data once `stall` falls.

Two configuration registers set the behaviour. The first holds the bus enable and one upper-sector wait bit. The second holds a three-bit sector limit, the two lower-sector wait bits and the other upper-sector wait bit. The limit splits the address space into a lower and an upper sector, and each sector has its own two-bit wait code. The wait code is chosen from the request address when the request is accepted.

A legacy-compatibility input reduces the wait selection to a single stretch bit. A bus-keeper option input chooses what the shared pins keep showing after a transfer: the data or the low address. A look-ahead input from the core says whether the following access also targets memory. When it does, an extra latch strobe is emitted in the final period of the current access.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset both configuration read-backs are 0x00, `stall`, `ale`, `adOe` and `busActive` are low, and `rdN` and `wrN` are high.
- R2: In register A, bit 7 is the bus enable and bit 6 is the high bit of the upper-sector wait code; its other bits read 0. In register B, bits 6:4 are the sector limit, bits 3:2 are the lower-sector wait code (bit 3 high), and bit 1 is the low bit of the upper-sector wait code. Bits 7 and 0 of register B always read 0, whatever is written.
- R3: `busActive` equals the enable bit. While the enable bit is clear, a request starts no access: `stall`, `ale`, `rdN` and `wrN` stay inactive and `addrHi` keeps its value.
- R4: The sector boundary is the limit times 0x2000. A request at or above the boundary uses the upper-sector code, and a request below it uses the lower-sector code. A limit of 0 puts every address in the upper sector.
- R5: Wait codes 00, 01, 10 and 11 give a strobe of 2, 3, 4 and 4 cycles and an access of 4, 5, 6 and 7 cycles. The access is counted in cycles with `stall` high. `rdN` and `wrN` are never low together.
- R6: With `legacyMode` high, the wait code is 0 followed by register A bit 6. The sector limit and the other wait bits have no effect.
- R7: `ale` is high in the first period of an access and low while a strobe is active. In the final period it is high exactly when `nextIsMem` is high. It is low in every other period.
- R8: While `rdN` is low, `adOe` is low. `rdData` takes the value of `adIn` at the clock edge that ends the last `rdN`-low cycle, and holds it after `stall` falls.
- R9: In every cycle with `wrN` low, `adOe` is high and `adOut` equals the request's write data.
- R10: After the strobe, `adOe` is low. `adOut` keeps the low address byte when `keeperOn` is high, and otherwise keeps the transferred data byte.
- R11: `addrHi` takes the high address byte on the edge that accepts a request and changes at no other time.
- R12: A request is accepted on a clock edge where `reqValid` is high, `stall` is low and the bus is enabled. `stall` rises on that edge, stays high through the final period and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrA | input | 1 | Write strobe for configuration register A |
| cfgWrB | input | 1 | Write strobe for configuration register B |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdA | output | 8 | Read-back of register A |
| cfgRdB | output | 8 | Read-back of register B |
| legacyMode | input | 1 | Single-bit wait selection mode |
| keeperOn | input | 1 | Keep the low address on the shared pins after a transfer |
| reqValid | input | 1 | Access request pulse from the core |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| nextIsMem | input | 1 | The following access also targets memory |
| rdData | output | DATA_W | Last read data |
| stall | output | 1 | An external access is in progress |
| busActive | output | 1 | Pins are in memory-bus function |
| addrHi | output | ADDR_W-DATA_W | High address byte |
| adOut | output | DATA_W | Shared address/data pin value |
| adOe | output | 1 | Shared pin output enable |
| adIn | input | DATA_W | Shared pin input value |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |

## Verification
The bench sweeps every sector limit against every pair of upper and lower wait codes. Each combination is tried at the bottom of the space, at the last address below the boundary, at the boundary itself and at the top address, so the cycle counts show whether the sector choice and the code-to-length mapping are correct on both sides of each boundary. Reads and writes alternate with the keeper and look-ahead inputs, so the value held on the shared pins and the final-period latch strobe are told apart for every case. A legacy sweep then sets conflicting sector bits to show that only the single stretch bit counts.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int REG_W   = 8;
  localparam int LIMIT_W = 3;
  localparam int CODE_W  = 2;
  localparam int CNT_W   = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_TAIL
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;      // request taken at this edge
    logic inAddr;      // first period: address out, latch strobe
    logic inStrobe;    // read or write strobe active
    logic strobeEnd;   // last strobe cycle
    logic lastPeriod;  // final period of the access
    logic isWrite;     // direction of the running access
  } busCtl_t;

  // strobe length in cycles for a wait code
  function automatic logic [CNT_W-1:0] strobeCycles(input logic [CODE_W-1:0] code);
    case (code)
      2'b00:   strobeCycles = 3'd2;
      2'b01:   strobeCycles = 3'd3;
      default: strobeCycles = 3'd4;
    endcase
  endfunction

  // trailing periods after the strobe for a wait code
  function automatic logic [CNT_W-1:0] tailCycles(input logic [CODE_W-1:0] code);
    tailCycles = (code == 2'b11) ? 3'd2 : 3'd1;
  endfunction

endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrA,
  input  logic                cfgWrB,
  input  logic [REG_W-1:0]    cfgWdata,
  input  logic                legacyMode,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic [REG_W-1:0]    cfgRdA,
  output logic [REG_W-1:0]    cfgRdB,
  output logic                enable,
  output logic [CODE_W-1:0]   waitCode
);

  localparam int LOW_W = ADDR_W - LIMIT_W;

  logic               enBit;
  logic               upWaitHi;
  logic               upWaitLo;
  logic [CODE_W-1:0]  loWait;
  logic [LIMIT_W-1:0] limit;
  logic [ADDR_W-1:0]  boundary;
  logic               isUpper;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      upWaitHi <= 1'b0;
    end else if (cfgWrA) begin
      enBit    <= cfgWdata[7];
      upWaitHi <= cfgWdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limit    <= '0;
      loWait   <= '0;
      upWaitLo <= 1'b0;
    end else if (cfgWrB) begin
      limit    <= cfgWdata[6:4];
      loWait   <= cfgWdata[3:2];
      upWaitLo <= cfgWdata[1];
    end
  end

  assign cfgRdA = {enBit, upWaitHi, 6'b000000};
  assign cfgRdB = {1'b0, limit, loWait, upWaitLo, 1'b0};
  assign enable = enBit;

  // boundary is the limit placed in the top address bits
  assign boundary = {limit, {LOW_W{1'b0}}};
  assign isUpper  = (reqAddr >= boundary);

  always_comb begin
    if (legacyMode)
      waitCode = {1'b0, upWaitHi};
    else if (isUpper)
      waitCode = {upWaitHi, upWaitLo};
    else
      waitCode = loWait;
  end

endmodule

// File: rtl/xbus_ctrl_fsm.sv
module xbus_ctrl_fsm
  import xbus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              enable,
  input  logic [CODE_W-1:0] waitCode,
  output busCtl_t           ctl,
  output logic              stall
);

  busState_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] codeLat;
  logic              wrLat;
  logic              accept;

  assign accept = (state == ST_IDLE) && reqValid && enable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      codeLat <= '0;
      wrLat   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_ADDR;
            codeLat <= waitCode;
            wrLat   <= reqWrite;
          end
        end
        ST_ADDR: begin
          state <= ST_STRB;
          cnt   <= strobeCycles(codeLat) - 3'd1;
        end
        ST_STRB: begin
          if (cnt == '0) begin
            state <= ST_TAIL;
            cnt   <= tailCycles(codeLat) - 3'd1;
          end else begin
            cnt <= cnt - 3'd1;
          end
        end
        ST_TAIL: begin
          if (cnt == '0)
            state <= ST_IDLE;
          else
            cnt <= cnt - 3'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.accept     = accept;
    ctl.inAddr     = (state == ST_ADDR);
    ctl.inStrobe   = (state == ST_STRB);
    ctl.strobeEnd  = (state == ST_STRB) && (cnt == '0);
    ctl.lastPeriod = (state == ST_TAIL) && (cnt == '0);
    ctl.isWrite    = wrLat;
  end

  assign stall = (state != ST_IDLE);

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busCtl_t                  ctl,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic                     keeperOn,
  input  logic                     nextIsMem,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        rdData,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] addrLo;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] holdReg;
  logic [HI_W-1:0]   hiReg;
  logic [DATA_W-1:0] rdReg;

  // capture the request at acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLo   <= '0;
      hiReg    <= '0;
      wdataReg <= '0;
    end else if (ctl.accept) begin
      addrLo   <= reqAddr[DATA_W-1:0];
      hiReg    <= reqAddr[ADDR_W-1:DATA_W];
      wdataReg <= reqWdata;
    end
  end

  // read sample and pin hold value at the end of the strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdReg   <= '0;
      holdReg <= '0;
    end else if (ctl.strobeEnd) begin
      if (!ctl.isWrite)
        rdReg <= adIn;
      if (keeperOn)
        holdReg <= addrLo;
      else if (ctl.isWrite)
        holdReg <= wdataReg;
      else
        holdReg <= adIn;
    end
  end

  always_comb begin
    if (ctl.inAddr)
      adOut = addrLo;
    else if (ctl.inStrobe && ctl.isWrite)
      adOut = wdataReg;
    else
      adOut = holdReg;
  end

  assign adOe   = ctl.inAddr || (ctl.inStrobe && ctl.isWrite);
  assign ale    = ctl.inAddr || (ctl.lastPeriod && nextIsMem);
  assign rdN    = !(ctl.inStrobe && !ctl.isWrite);
  assign wrN    = !(ctl.inStrobe && ctl.isWrite);
  assign rdData = rdReg;
  assign addrHi = hiReg;

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWrA,
  input  logic                     cfgWrB,
  input  logic [REG_W-1:0]         cfgWdata,
  output logic [REG_W-1:0]         cfgRdA,
  output logic [REG_W-1:0]         cfgRdB,
  input  logic                     legacyMode,
  input  logic                     keeperOn,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic                     nextIsMem,
  output logic [DATA_W-1:0]        rdData,
  output logic                     stall,
  output logic                     busActive,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN
);

  logic              enable;
  logic [CODE_W-1:0] waitCode;
  busCtl_t           ctl;

  xbus_cfg #(.ADDR_W(ADDR_W)) cfg_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrA     (cfgWrA),
    .cfgWrB     (cfgWrB),
    .cfgWdata   (cfgWdata),
    .legacyMode (legacyMode),
    .reqAddr    (reqAddr),
    .cfgRdA     (cfgRdA),
    .cfgRdB     (cfgRdB),
    .enable     (enable),
    .waitCode   (waitCode)
  );

  xbus_ctrl_fsm fsm_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .enable   (enable),
    .waitCode (waitCode),
    .ctl      (ctl),
    .stall    (stall)
  );

  xbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .keeperOn  (keeperOn),
    .nextIsMem (nextIsMem),
    .adIn      (adIn),
    .rdData    (rdData),
    .addrHi    (addrHi),
    .adOut     (adOut),
    .adOe      (adOe),
    .ale       (ale),
    .rdN       (rdN),
    .wrN       (wrN)
  );

  assign busActive = enable;

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [7:0]      cfgRdB,
  input logic            reqValid,
  input logic            stall,
  input logic            busActive,
  input logic [HI_W-1:0] addrHi,
  input logic            adOe,
  input logic            ale,
  input logic            rdN,
  input logic            wrN
);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdB[7] == 1'b0) && (cfgRdB[0] == 1'b0)); // R2

  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !busActive) |=> !stall); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R5

  AST_ALE_OFF_IN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN)); // R7

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe); // R8

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> adOe); // R9

  AST_ADDRHI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(stall) |-> $stable(addrHi)); // R11

  AST_STALL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !stall && busActive) |=> stall); // R12

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.HI_W(ADDR_W-DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cfgRdB    (cfgRdB),
  .reqValid  (reqValid),
  .stall     (stall),
  .busActive (busActive),
  .addrHi    (addrHi),
  .adOe      (adOe),
  .ale       (ale),
  .rdN       (rdN),
  .wrN       (wrN)
);

// File: tb/xbus_ctrl_tb_top.sv
module xbus_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int WATCHDOG_CYCLES = 150000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrA = 1'b0;
  logic          cfgWrB = 1'b0;
  logic [7:0]    cfgWdata = '0;
  logic [7:0]    cfgRdA;
  logic [7:0]    cfgRdB;
  logic          legacyMode = 1'b0;
  logic          keeperOn = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          nextIsMem = 1'b0;
  logic [DW-1:0] rdData;
  logic          stall;
  logic          busActive;
  logic [AW-DW-1:0] addrHi;
  logic [DW-1:0] adOut;
  logic          adOe;
  logic [DW-1:0] adIn;
  logic          ale;
  logic          rdN;
  logic          wrN;

  int nChecks = 0;
  int nErrors = 0;
  logic [AW-1:0] curAddr = '0;

  function automatic logic [7:0] patt(input logic [15:0] a);
    patt = a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory model: drive pattern only while the read strobe is low
  assign adIn = !rdN ? patt(curAddr) : 8'h3C;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrA(cfgWrA), .cfgWrB(cfgWrB), .cfgWdata(cfgWdata),
    .cfgRdA(cfgRdA), .cfgRdB(cfgRdB), .legacyMode(legacyMode), .keeperOn(keeperOn),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .nextIsMem(nextIsMem), .rdData(rdData), .stall(stall), .busActive(busActive),
    .addrHi(addrHi), .adOut(adOut), .adOe(adOe), .adIn(adIn), .ale(ale),
    .rdN(rdN), .wrN(wrN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input bit selA, input logic [7:0] d);
    @(negedge clk);
    cfgWrA = selA; cfgWrB = !selA; cfgWdata = d;
    @(negedge clk);
    cfgWrA = 1'b0; cfgWrB = 1'b0;
  endtask

  // one access; code is the wait code the bench expects
  task automatic doAccess(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                          input int code, input bit keep, input bit nxt, input string lenTag);
    int nStall = 0; int nRd = 0; int nWr = 0; int nAle = 0;
    bit aleFirst = 0; bit aleLast = 0; bit wrOk = 1; bit hiOk = 1;
    int strobeExp = 2 + ((code > 2) ? 2 : code);
    int totalExp  = 1 + strobeExp + ((code == 3) ? 2 : 1);
    logic [7:0] holdExp;
    @(negedge clk);
    keeperOn = keep; nextIsMem = nxt; curAddr = addr;
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (stall === 1'b1 && nStall < 20) begin
      nStall++;
      if (!rdN) nRd++;
      if (!wrN) begin
        nWr++;
        if (!(adOe === 1'b1 && adOut === wd)) wrOk = 0;
      end
      if (ale) nAle++;
      if (nStall == 1) aleFirst = ale;
      aleLast = ale;
      if (addrHi !== addr[15:8]) hiOk = 0;
      @(negedge clk);
    end
    check(nStall == totalExp, "R12 access length", nStall, totalExp);
    check((wr ? nWr : nRd) == strobeExp, lenTag, wr ? nWr : nRd, strobeExp);
    check((wr ? nRd : nWr) == 0, "R5 wrong strobe", wr ? nRd : nWr, 0);
    check(aleFirst == 1'b1 && aleLast == nxt && nAle == 1 + int'(nxt),
          "R7 ale count", nAle, 1 + int'(nxt));
    if (wr) check(wrOk, "R9 write data on pins", adOut, wd);
    else    check(rdData === patt(addr), "R8 read data", rdData, patt(addr));
    holdExp = keep ? addr[7:0] : (wr ? wd : patt(addr));
    check(adOut === holdExp && adOe === 1'b0, "R10 held pin value", adOut, holdExp);
    check(hiOk && addrHi === addr[15:8], "R11 high address", addrHi, addr[15:8]);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog: actual=%0d expected=done", WATCHDOG_CYCLES);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cfgRdA == 8'h00 && cfgRdB == 8'h00, "R1 config reset", {cfgRdA, cfgRdB}, 0);
    check(stall == 1'b0 && ale == 1'b0 && adOe == 1'b0 && busActive == 1'b0,
          "R1 outputs reset", {stall, ale, adOe, busActive}, 0);
    check(rdN == 1'b1 && wrN == 1'b1, "R1 strobes reset", {rdN, wrN}, 3);
    rstN = 1'b1;

    // R2 layout and reserved bits
    writeReg(1'b0, 8'hFF);
    check(cfgRdB == 8'h7E, "R2 register B reserved", cfgRdB, 8'h7E);
    writeReg(1'b0, 8'h81);
    check(cfgRdB == 8'h00, "R2 register B reserved only", cfgRdB, 8'h00);
    writeReg(1'b1, 8'h7F);
    check(cfgRdA == 8'h40, "R2 register A bits", cfgRdA, 8'h40);

    // R3 disabled bus ignores requests
    writeReg(1'b1, 8'h00);
    writeReg(1'b0, 8'h00);
    check(busActive == 1'b0, "R3 busActive off", busActive, 0);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'hABCD; reqWdata = 8'h11;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(stall == 1'b0 && ale == 1'b0 && wrN == 1'b1 && rdN == 1'b1,
            "R3 no access while disabled", {stall, ale, wrN, rdN}, 3);
      @(negedge clk);
    end
    check(addrHi == 8'h00, "R3 high address untouched", addrHi, 0);
    writeReg(1'b1, 8'h80);
    check(busActive == 1'b1, "R3 busActive on", busActive, 1);

    // R4 / R5 sweep: limit x upper code x lower code x boundary addresses
    for (int lim = 0; lim < 8; lim++) begin
      for (int up = 0; up < 4; up++) begin
        for (int lo = 0; lo < 4; lo++) begin
          logic [15:0] bnd;
          logic [15:0] addrs [4];
          bnd = 16'(lim) << 13;
          writeReg(1'b1, {1'b1, up[1], 6'b0});
          writeReg(1'b0, {1'b0, lim[2:0], lo[1:0], up[0], 1'b0});
          addrs[0] = 16'h0000;
          addrs[1] = (lim == 0) ? 16'h1234 : bnd - 16'd1;
          addrs[2] = (lim == 0) ? 16'h8000 : bnd;
          addrs[3] = 16'hFFFF;
          for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 2; w++) begin
              int code;
              code = (addrs[k] >= bnd) ? up : lo;
              doAccess(w[0], addrs[k], 8'(addrs[k][7:0] + 8'(lim * 16 + up * 4 + lo)),
                       code, k[0] ^ w[0], k[1], "R4 R5 strobe length by sector");
            end
          end
        end
      end
    end

    // R6 legacy sweep: sector bits set against the single stretch bit
    legacyMode = 1'b1;
    for (int b = 0; b < 2; b++) begin
      writeReg(1'b1, {1'b1, b[0], 6'b0});
      writeReg(1'b0, 8'b0_011_11_1_0);
      for (int k = 0; k < 4; k++) begin
        for (int w = 0; w < 2; w++) begin
          logic [15:0] a;
          a = 16'(k) * 16'h5000 + 16'h0123;
          doAccess(w[0], a, 8'(8'hC3 ^ a[7:0]), b, w[0], !w[0], "R6 legacy strobe length");
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule